// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two 8-bit buses, an A side and a B side. In each direction it either passes the opposite bus straight through or replays a value held in a storage register for that direction. Each register has its own capture clock. Each direction also has its own select, which picks between live data and stored data.

One active-low enable and one direction input decide which side, if any, is driven. Each bus is carried as separate input, output and output-enable signals, so the pad-level tri-state lives outside the block. The registers keep capturing while both sides are released. This lets a value be parked in a register and sent out later.

A build-time parameter inverts the data on both transfer paths. By default the data is not inverted.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_a2b`, the A-to-B register takes the value of `a_in`. It holds that value at all other times, including while `clk_a2b` stays high and `a_in` changes.
- R2: On each rising edge of `clk_b2a`, the B-to-A register takes the value of `b_in`. A `clk_a2b` edge never changes this register, and a `clk_b2a` edge never changes the A-to-B register.
- R3: While `oe_n` is 0, `dir` = 1 sets `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 sets `a_oe` = 1 and `b_oe` = 0. This decode is combinational.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 whatever `dir` and the selects are. Register capture still works in this state.
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: While B is driven, `sel_a2b` = 0 puts the live `a_in` on `b_out`, and `sel_a2b` = 1 puts the A-to-B register contents on `b_out`. There is no added latency.
- R7: While A is driven, `sel_b2a` = 0 puts the live `b_in` on `a_out`, and `sel_b2a` = 1 puts the B-to-A register contents on `a_out`. There is no added latency.
- R8: With `INVERT` = 1, every driven value is the bitwise complement of the chosen source on both paths. With the default `INVERT` = 0, it is the source unchanged.
- R9: A side whose output enable is 0 presents all zeros on its output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_b2a | input | 1 | Capture clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Shared output enable, active low |
| dir | input | 1 | 1: drive B from A path; 0: drive A from B path |
| sel_a2b | input | 1 | B-side source: 0 live A bus, 1 stored A-to-B value |
| sel_b2a | input | 1 | A-side source: 0 live B bus, 1 stored B-to-A value |
| a_in | input | W | Data seen on the A bus |
| a_out | output | W | Data driven onto the A bus |
| a_oe | output | 1 | A bus driver enable |
| b_in | input | W | Data seen on the B bus |
| b_out | output | W | Data driven onto the B bus |
| b_oe | output | 1 | B bus driver enable |

## Verification
The case hardest to reach from the ports is a stored value that differs from the live bus at the moment it is replayed. A stored-mode check where both match would pass on a design that ignores the register. The bench therefore captures with both sides released, then changes both input buses to new patterns before enabling the output. It also changes the input while a capture clock is still high, to show that only the rising edge loads the register. A model of both registers in the bench is updated only when the bench itself pulses a clock. Every combination of enable, direction and the two selects is then compared against this model.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } side_t;

  // Which bus the block drives for a given enable/direction pair.
  function automatic side_t pick_side(input logic oe_n, input logic dir);
    if (oe_n) return SIDE_NONE;
    return dir ? SIDE_B : SIDE_A;
  endfunction
endpackage

// File: rtl/bxr_capture.sv
module bxr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // No reset: contents are undefined until the first edge.
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/bxr_path_mux.sv
module bxr_path_mux #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] FLIP = {W{INVERT}};
  logic [W-1:0] src;

  always_comb begin
    src  = sel ? stored : live;
    dout = en ? (src ^ FLIP) : '0;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import bxr_pkg::*;

  side_t        side;
  logic [W-1:0] stored_ab;
  logic [W-1:0] stored_ba;

  assign side = pick_side(oe_n, dir);
  assign a_oe = (side == SIDE_A);
  assign b_oe = (side == SIDE_B);

  bxr_capture #(.W(W)) u_reg_ab (.clk(clk_a2b), .d(a_in), .q(stored_ab));
  bxr_capture #(.W(W)) u_reg_ba (.clk(clk_b2a), .d(b_in), .q(stored_ba));

  bxr_path_mux #(.W(W), .INVERT(INVERT)) u_mux_b (
    .live(a_in), .stored(stored_ab), .sel(sel_a2b), .en(b_oe), .dout(b_out)
  );
  bxr_path_mux #(.W(W), .INVERT(INVERT)) u_mux_a (
    .live(b_in), .stored(stored_ba), .sel(sel_b2a), .en(a_oe), .dout(a_out)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         oe_n,
  input logic         dir,
  input logic         sel_a2b,
  input logic         sel_b2a,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  localparam logic [W-1:0] FLIP = {W{INVERT}};
  logic known;
  assign known = !$isunknown({oe_n, dir, sel_a2b, sel_b2a, a_in, b_in});

  always_comb begin
    if (known) begin
      AST_ONE_DRIVER: assert (!(a_oe && b_oe));                                  // R5
      AST_QUIET_ISO:  assert (!oe_n || (!a_oe && !b_oe));                        // R4
      AST_DIR_B:      assert (oe_n || !dir || (b_oe && !a_oe));                  // R3
      AST_DIR_A:      assert (oe_n || dir || (a_oe && !b_oe));                   // R3
      AST_IDLE_A:     assert (a_oe || a_out == '0);                              // R9
      AST_IDLE_B:     assert (b_oe || b_out == '0);                              // R9
      AST_LIVE_AB:    assert (!b_oe || sel_a2b || b_out == (a_in ^ FLIP));       // R6
      AST_LIVE_BA:    assert (!a_oe || sel_b2a || a_out == (b_in ^ FLIP));       // R7
    end
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .oe_n(oe_n), .dir(dir), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  logic       sys_clk = 1'b0;
  logic       clk_a2b = 1'b0, clk_b2a = 1'b0;
  logic       oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] a_out, b_out, ia_out, ib_out;
  logic       a_oe, b_oe, ia_oe, ib_oe;
  logic [7:0] m_ab, m_ba;   // bench model of the two registers
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 sys_clk = ~sys_clk;  // 250 MHz

  bus_xcvr_reg uut (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .oe_n(oe_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );
  bus_xcvr_reg #(.W(8), .INVERT(1'b1)) uut_inv (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .oe_n(oe_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, let combinational paths settle.
  task automatic drive(input logic o, input logic d, input logic sa, input logic sb,
                       input logic [7:0] av, input logic [7:0] bv);
    @(negedge sys_clk);
    oe_n = o; dir = d; sel_a2b = sa; sel_b2a = sb; a_in = av; b_in = bv;
    #1;
  endtask

  task automatic pulse_ab();
    @(negedge sys_clk); clk_a2b = 1'b1; m_ab = a_in;
    @(negedge sys_clk); clk_a2b = 1'b0; #1;
  endtask

  task automatic pulse_ba();
    @(negedge sys_clk); clk_b2a = 1'b1; m_ba = b_in;
    @(negedge sys_clk); clk_b2a = 1'b0; #1;
  endtask

  // Full reference comparison against the bench model.
  task automatic compare(input string req);
    logic ea, eb;
    logic [7:0] ev_a, ev_b;
    eb = !oe_n && dir;
    ea = !oe_n && !dir;
    ev_b = eb ? (sel_a2b ? m_ab : a_in) : 8'h00;
    ev_a = ea ? (sel_b2a ? m_ba : b_in) : 8'h00;
    chk({req, " R3 b_oe"}, {7'd0, b_oe}, {7'd0, eb});
    chk({req, " R3 a_oe"}, {7'd0, a_oe}, {7'd0, ea});
    chk({req, " R6/R9 b_out"}, b_out, ev_b);
    chk({req, " R7/R9 a_out"}, a_out, ev_a);
  endtask

  task automatic t_isolation();
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, k[0], k[1], k[2], 8'hFF, 8'hFF);
      chk("R4 iso a_oe", {7'd0, a_oe}, 8'h00);
      chk("R4 iso b_oe", {7'd0, b_oe}, 8'h00);
      chk("R9 iso a_out", a_out, 8'h00);
      chk("R9 iso b_out", b_out, 8'h00);
    end
  endtask

  task automatic t_store_in_iso();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5);
    pulse_ab();
    pulse_ba();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h81, 8'h7E);
    chk("R4/R1/R6 replay stored A-to-B", b_out, 8'h3C);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h81, 8'h7E);
    chk("R4/R2/R7 replay stored B-to-A", a_out, 8'hA5);
  endtask

  task automatic t_edge_only();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h99);
    @(negedge sys_clk); clk_a2b = 1'b1; m_ab = 8'h11;
    #1 a_in = 8'h22;
    @(negedge sys_clk); clk_a2b = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h33, 8'h99);
    chk("R1 level-high change ignored", b_out, 8'h11);
  endtask

  task automatic t_independent();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3);
    pulse_ba();                    // m_ba = C3
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hE7, 8'h00);
    pulse_ab();                    // m_ab = E7
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    chk("R2 B-to-A untouched by A clock", a_out, 8'hC3);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h6B);
    pulse_ba();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R2 A-to-B untouched by B clock", b_out, 8'hE7);
  endtask

  task automatic t_all_modes();
    logic [7:0] pa [4] = '{8'h00, 8'hFF, 8'h55, 8'h96};
    logic [7:0] pb [4] = '{8'hFF, 8'h00, 8'hAA, 8'h4D};
    for (int p = 0; p < 4; p++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, pa[p] ^ 8'h0F, pb[p] ^ 8'hF0);
      pulse_ab();
      pulse_ba();
      for (int k = 0; k < 16; k++) begin
        drive(k[3], k[2], k[1], k[0], pa[p], pb[p]);
        compare("modes");
        n_run++;
        if (a_oe && b_oe) begin
          n_fail++;
          $display("FAIL R5: both enables high (actual 1/1, expected not both)");
        end
      end
    end
  endtask

  task automatic t_invert();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hC6, 8'h39);
    pulse_ab();
    pulse_ba();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h12, 8'h34);
    chk("R8 inverted live A-to-B", ib_out, 8'hED);
    chk("R8 default live A-to-B", b_out, 8'h12);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h12, 8'h34);
    chk("R8 inverted stored A-to-B", ib_out, 8'h39);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34);
    chk("R8 inverted live B-to-A", ia_out, 8'hCB);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h34);
    chk("R8 inverted stored B-to-A", ia_out, 8'hC6);
    chk("R8 default stored B-to-A", a_out, 8'h39);
    chk("R9 inverted idle side zero", ib_out, 8'h00);
  endtask

  initial begin
    #1;
    chk("R4 initial a_oe", {7'd0, a_oe}, 8'h00);
    chk("R4 initial b_oe", {7'd0, b_oe}, 8'h00);
    t_isolation();
    t_store_in_iso();
    t_edge_only();
    t_independent();
    t_all_modes();
    t_invert();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule